// File: doc/BRIEF.md
# Dual-Channel Byte-Loaded Double-Buffered Code Register

This block is the digital register section for a pair of 12-bit converter channels that are fed from an 8-bit data bus. Each channel assembles its 12-bit code from two byte writes into a first rank of input registers: an 8-bit low part and a 4-bit high part. The bytes may arrive in either order. A channel-select input and a byte-select input steer each write to one register.

A second rank holds the codes that reach the outputs. One shared load strobe copies both assembled words into the output rank on the same clock edge, so both channels change together. A shared clear strobe forces both output codes to zero and leaves the input rank untouched. A later load therefore brings back the last words that were written. All strobes are active-low and are sampled on the rising clock edge.

Top module: `dual_byte_dac_regs`

## Requirements
- R1: With `byte_sel` = 0, a write (`wr_n` low) stores `din[7:0]` as bits 7..0 of the selected channel's word.
- R2: With `byte_sel` = 1, a write stores `din[3:0]` as bits 11..8 of the selected channel's word. `din[7:4]` has no effect.
- R3: The two byte writes of one word may come in either order, low then high or high then low, and give the same word after a load.
- R4: `ch_sel` = 0 selects channel A (`code_a`) and `ch_sel` = 1 selects channel B (`code_b`). A write changes only the selected channel's selected input register. The other three input registers and both outputs hold their values.
- R5: When `load_n` is low at a rising edge and `clr_n` is high, both outputs take their channel's input word on that same edge.
- R6: When `clr_n` is low at a rising edge, both outputs are 0 after that edge, even if `load_n` is also low.
- R7: A clear leaves the input registers unchanged, so a load after a clear restores the last written words.
- R8: When a write and a load fall on the same edge, the output receives the input word as it was before that write. The newly written byte appears only after a later load.
- R9: Outputs change only at a rising edge where `clr_n` or `load_n` is low. With both high, the outputs hold regardless of writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all strobes are sampled on its rising edge |
| clr_n | input | 1 | Active-low clear of both output codes |
| wr_n | input | 1 | Active-low byte write strobe |
| load_n | input | 1 | Active-low shared transfer of input words to outputs |
| ch_sel | input | 1 | Channel select: 0 = A, 1 = B |
| byte_sel | input | 1 | Byte select: 0 = low byte, 1 = high nibble |
| din | input | 8 | Data bus, bit 7 most significant |
| code_a | output | 12 | Channel A output code |
| code_b | output | 12 | Channel B output code |

## Verification
The collisions that matter are a write coinciding with a load, and a clear coinciding with a load. The first must move the old word into the output while the new byte still lands in the input rank. The second must give zero and keep the input rank for a later load. The bench provokes both with directed sequences first and then with random strobe patterns that often overlap. A bench model applies the priority order clear, then load, then write-into-input, and each cycle's outputs are compared against it one step after the edge.

// File: rtl/dbuf_pkg.sv
package dbuf_pkg;

   typedef enum logic {
      CHAN_A = 1'b0,
      CHAN_B = 1'b1
   } chan_e;

   typedef enum logic {
      PART_LO = 1'b0,
      PART_HI = 1'b1
   } part_e;

   localparam int unsigned NUM_CHAN = 2;

endpackage

// File: rtl/dbuf_wr_decode.sv
module dbuf_wr_decode
   import dbuf_pkg::*;
#(
   parameter int unsigned N_CH = NUM_CHAN
) (
   input  logic            wr_n,
   input  logic            ch_sel,
   input  logic            byte_sel,
   output logic [N_CH-1:0] wr_lo,
   output logic [N_CH-1:0] wr_hi
);

   chan_e ch_q;
   part_e part_q;

   assign ch_q   = chan_e'(ch_sel);
   assign part_q = part_e'(byte_sel);

   for (genvar c = 0; c < N_CH; c++) begin : g_ch
      logic hit;
      assign hit      = !wr_n && (int'(ch_q) == c);
      assign wr_lo[c] = hit && (part_q == PART_LO);
      assign wr_hi[c] = hit && (part_q == PART_HI);
   end

endmodule

// File: rtl/dbuf_in_reg.sv
module dbuf_in_reg #(
   parameter int unsigned BUS_W  = 8,
   parameter int unsigned WORD_W = 12
) (
   input  logic              clk,
   input  logic              clr_n,
   input  logic              wr_lo,
   input  logic              wr_hi,
   input  logic [BUS_W-1:0]  din,
   output logic [WORD_W-1:0] word
);

   localparam int unsigned HI_W = WORD_W - BUS_W;

   if (HI_W < 1 || HI_W > BUS_W) begin : g_bad_width
      $error("dbuf_in_reg: WORD_W must lie between BUS_W+1 and 2*BUS_W");
   end

   logic [BUS_W-1:0] lo_q;
   logic [HI_W-1:0]  hi_q;

   always_ff @(posedge clk) begin
      if (wr_lo) lo_q <= din;
   end

   always_ff @(posedge clk) begin
      if (wr_hi) hi_q <= din[HI_W-1:0];
   end

   assign word = {hi_q, lo_q};

   p_lo_capture_r1: assert property (@(posedge clk) disable iff (!clr_n)
      wr_lo |=> word[BUS_W-1:0] == $past(din));

   p_hi_capture_r2: assert property (@(posedge clk) disable iff (!clr_n)
      wr_hi |=> word[WORD_W-1:BUS_W] == $past(din[HI_W-1:0]));

   p_hi_kept_on_lo_r4: assert property (@(posedge clk) disable iff (!clr_n)
      (wr_lo && !wr_hi) |=> $stable(word[WORD_W-1:BUS_W]));

   p_lo_kept_on_hi_r4: assert property (@(posedge clk) disable iff (!clr_n)
      (wr_hi && !wr_lo) |=> $stable(word[BUS_W-1:0]));

endmodule

// File: rtl/dbuf_out_reg.sv
module dbuf_out_reg #(
   parameter int unsigned WORD_W = 12
) (
   input  logic              clk,
   input  logic              clr_n,
   input  logic              load_n,
   input  logic [WORD_W-1:0] word_in,
   output logic [WORD_W-1:0] code
);

   always_ff @(posedge clk) begin
      if (!clr_n)       code <= '0;
      else if (!load_n) code <= word_in;
   end

   p_clear_zero_r6: assert property (@(posedge clk)
      !clr_n |=> code == '0);

   p_load_copy_r5: assert property (@(posedge clk) disable iff (!clr_n)
      !load_n |=> code == $past(word_in));

   p_idle_hold_r9: assert property (@(posedge clk) disable iff (!clr_n)
      load_n |=> $stable(code));

endmodule

// File: rtl/dual_byte_dac_regs.sv
module dual_byte_dac_regs
   import dbuf_pkg::*;
#(
   parameter int unsigned BUS_W  = 8,
   parameter int unsigned WORD_W = 12
) (
   input  logic              clk,
   input  logic              clr_n,
   input  logic              wr_n,
   input  logic              load_n,
   input  logic              ch_sel,
   input  logic              byte_sel,
   input  logic [BUS_W-1:0]  din,
   output logic [WORD_W-1:0] code_a,
   output logic [WORD_W-1:0] code_b
);

   localparam int unsigned N_CH = NUM_CHAN;

   if (N_CH != 2) begin : g_bad_count
      $error("dual_byte_dac_regs: exactly two channels are supported");
   end

   logic [N_CH-1:0]   wr_lo;
   logic [N_CH-1:0]   wr_hi;
   logic [WORD_W-1:0] in_word [N_CH];
   logic [WORD_W-1:0] code_q  [N_CH];

   dbuf_wr_decode #(.N_CH(N_CH)) u_dec (
      .wr_n     (wr_n),
      .ch_sel   (ch_sel),
      .byte_sel (byte_sel),
      .wr_lo    (wr_lo),
      .wr_hi    (wr_hi)
   );

   for (genvar c = 0; c < N_CH; c++) begin : g_chan
      dbuf_in_reg #(.BUS_W(BUS_W), .WORD_W(WORD_W)) u_in (
         .clk   (clk),
         .clr_n (clr_n),
         .wr_lo (wr_lo[c]),
         .wr_hi (wr_hi[c]),
         .din   (din),
         .word  (in_word[c])
      );

      dbuf_out_reg #(.WORD_W(WORD_W)) u_out (
         .clk     (clk),
         .clr_n   (clr_n),
         .load_n  (load_n),
         .word_in (in_word[c]),
         .code    (code_q[c])
      );
   end

   assign code_a = code_q[0];
   assign code_b = code_q[1];

   p_pair_update_r5: assert property (@(posedge clk) disable iff (!clr_n)
      !load_n |=> (code_a == $past(in_word[0])) && (code_b == $past(in_word[1])));

   p_other_chan_kept_r4: assert property (@(posedge clk) disable iff (!clr_n)
      (!wr_n && ch_sel == 1'b0) |=> $stable(in_word[1]));

   p_write_no_output_r9: assert property (@(posedge clk) disable iff (!clr_n)
      (load_n && !wr_n) |=> $stable(code_a) && $stable(code_b));

endmodule

// File: tb/sim_dual_byte_dac_regs.sv
module sim_dual_byte_dac_regs;

   localparam int CLK_PERIOD = 10;
   localparam int N_RANDOM   = 600;

   logic        clk = 1'b0;
   logic        clr_n = 1'b1;
   logic        wr_n = 1'b1;
   logic        load_n = 1'b1;
   logic        ch_sel = 1'b0;
   logic        byte_sel = 1'b0;
   logic [7:0]  din = '0;
   logic [11:0] code_a;
   logic [11:0] code_b;

   int n_chk  = 0;
   int n_fail = 0;

   logic [7:0]  m_lo [2];
   logic [3:0]  m_hi [2];
   logic [11:0] m_out [2];

   always #(CLK_PERIOD/2) clk = ~clk;

   dual_byte_dac_regs u0 (
      .clk(clk), .clr_n(clr_n), .wr_n(wr_n), .load_n(load_n),
      .ch_sel(ch_sel), .byte_sel(byte_sel), .din(din),
      .code_a(code_a), .code_b(code_b)
   );

   function automatic logic [11:0] word_of(input int c);
      return {m_hi[c], m_lo[c]};
   endfunction

   task automatic check(input string tag, input logic [11:0] act, input logic [11:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic step(input string tag, input logic c, input logic w, input logic l,
                       input logic ch, input logic bs, input logic [7:0] d);
      @(negedge clk);
      clr_n = c; wr_n = w; load_n = l; ch_sel = ch; byte_sel = bs; din = d;
      @(posedge clk);
      if (!c) begin
         m_out[0] = '0; m_out[1] = '0;
      end else if (!l) begin
         m_out[0] = word_of(0); m_out[1] = word_of(1);
      end
      if (!w) begin
         if (bs) m_hi[ch] = d[3:0];
         else    m_lo[ch] = d;
      end
      #1;
      check({tag, " chA"}, code_a, m_out[0]);
      check({tag, " chB"}, code_b, m_out[1]);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      m_lo[0] = '0; m_lo[1] = '0; m_hi[0] = '0; m_hi[1] = '0;
      m_out[0] = '0; m_out[1] = '0;

      // R6 reset state
      step("R6 reset", 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00);
      step("R6 reset", 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00);

      // R1 / R2: channel A low then high (upper nibble on bus must be ignored)
      step("R1 lo A", 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 8'h3C);
      step("R2 hi A", 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 8'hA7);
      // R3: channel B high first, then low
      step("R3 hi B", 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 8'hF9);
      step("R3 lo B", 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 8'h81);
      // R9 idle holds
      step("R9 idle", 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 8'hFF);
      // R5 shared load
      step("R5 load", 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00);
      check("R2 nibble A", code_a, 12'h73C);
      check("R3 order B", code_b, 12'h981);

      // R4: write to A low only; B and outputs unchanged until load
      step("R4 sel", 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 8'h55);
      step("R4 load", 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00);
      check("R4 B untouched", code_b, 12'h981);

      // R8: write and load on same edge
      step("R8 wr+ld", 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 8'h02);
      check("R8 old word", code_b, 12'h981);
      step("R8 later ld", 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00);
      check("R8 new word", code_b, 12'h281);

      // R6 clear over load, R7 restore
      step("R6 clr+ld", 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00);
      check("R6 zero A", code_a, 12'h000);
      step("R7 restore", 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00);
      check("R7 word A", code_a, 12'h755);
      check("R7 word B", code_b, 12'h281);

      // random mix with frequent strobe collisions
      for (int i = 0; i < N_RANDOM; i++) begin
         logic c, w, l;
         string tag;
         c = ($urandom % 16) != 0;
         w = ($urandom % 2) != 0;
         l = ($urandom % 3) != 0;
         if (!c)            tag = "R6 rnd";
         else if (!l && !w) tag = "R8 rnd";
         else if (!l)       tag = "R5 rnd";
         else if (!w)       tag = "R4 rnd";
         else               tag = "R9 rnd";
         step(tag, c, w, l, 1'($urandom), 1'($urandom), 8'($urandom));
      end

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

endmodule